// File: doc/BRIEF.md
# Serial Panel Register Access Master

This block lets on-chip logic read and write the 16-bit configuration registers of a display panel over a four-wire serial link. Chip select is active low. The serial clock idles high. Each transfer is a 24-bit frame sent most significant bit first. The leading byte of every frame is a fixed six-bit device code followed by a two-bit frame-type field. The remaining 16 bits carry a register number, write data, or zeros while read data is shifted in.

A register write sends two frames, each framed by its own chip-select pulse. The first is an index frame that names the register. The second is a data frame that carries the value. A register read sends the same index frame, then a data-read frame. The block returns the low 16 bits that the panel shifted back during that second frame. A status read is a single frame, and its low 16 received bits are returned.

A parameter sets the half-bit period in system clocks. The same count sets the chip-select setup time and the chip-select high gap after every frame.

Top module: `panel_reg_spi`

## Requirements
- R1: After reset, cs_n, sclk and mosi are high, and busy, done and rdata are all zero.
- R2: Every frame is exactly 24 sclk rising edges with cs_n held low, and data is sent most significant bit first. cs_n rises only after the last bit.
- R3: The top byte of every frame is {DEV_ID, type}, which is 0x74 | type with the default DEV_ID of 0x1D. The type codes are 00 index write, 01 status read, 10 data write and 11 data read.
- R4: With req_op = 00 (write), the block sends an index frame {0x74, 0x00, req_reg}, then a data-write frame {0x76, req_wdata}.
- R5: With req_op = 01 (read), the block sends the same index frame, then a data-read frame {0x77, 0x0000}. rdata becomes the low 16 bits shifted in on miso during the data-read frame.
- R6: With req_op[1] = 1 (status), the block sends a single frame {0x75, 0x0000}. rdata becomes the low 16 bits shifted in during that frame.
- R7: sclk falls and mosi is driven at the start of each bit. miso is sampled at the end of the low half. mosi never changes while sclk is high inside a frame.
- R8: Each frame occupies 50*HALF_DIV clocks: a HALF_DIV chip-select setup, 48 half-bit periods and a HALF_DIV cs_n-high gap. Between the two frames of an access, cs_n stays high for HALF_DIV clocks.
- R9: busy is high from the clock after a request is accepted until done. done is a one-cycle pulse, and busy is low in that cycle. Requests presented while busy are ignored.
- R10: A write access leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 00 write, 01 read, 1x status read |
| req_reg | input | 8 | Register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read or status result |
| cs_n | output | 1 | Panel chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the panel |
| miso | input | 1 | Serial data from the panel |

## Verification
Completion and acceptance can fall in adjacent cycles. A request may be held asserted through the done pulse, and the block must take it on the very next edge without losing the earlier result. The bench provokes this by keeping req_valid high while a read finishes, with a write already queued on the request inputs. It judges the outcome by checking three things: busy and a low cs_n in the cycle right after done, the read result still correct, and the captured frames of the following write matching the new fields. A second case presents requests in the middle of an access. It is judged by the count and contents of the frames the bench's panel model captures.

// File: rtl/panel_reg_spi.sv
module panel_reg_spi #(
  parameter int HALF_DIV = 2,
  parameter logic [5:0] DEV_ID = 6'h1D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [7:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam int FBITS = 24;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_GAP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [23:0] sh, rx;
  logic [4:0]  bitn;
  logic        last;
  logic [1:0]  op_q;
  logic [15:0] wd_q;

  wire tick = (cnt == CW'(HALF_DIV - 1));

  function automatic logic [23:0] frame(input logic [1:0] kind, input logic [15:0] pay);
    return {DEV_ID, kind, pay};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; rx <= '0; bitn <= '0;
      last <= 1'b0; op_q <= '0; wd_q <= '0;
      busy <= 1'b0; done <= 1'b0; rdata <= '0;
      cs_n <= 1'b1; sclk <= 1'b1; mosi <= 1'b1;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= '0;
        if (req_valid) begin
          busy <= 1'b1;
          cs_n <= 1'b0;
          op_q <= req_op;
          wd_q <= req_wdata;
          bitn <= '0;
          if (req_op[1]) begin
            sh <= frame(2'b01, 16'h0000);
            last <= 1'b1;
          end else begin
            sh <= frame(2'b00, {8'h00, req_reg});
            last <= 1'b0;
          end
          st <= S_SETUP;
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_SETUP: begin
            sclk <= 1'b0;
            mosi <= sh[23];
            st <= S_LOW;
          end
          S_LOW: begin
            rx <= {rx[22:0], miso};
            sclk <= 1'b1;
            st <= S_HIGH;
          end
          S_HIGH: begin
            if (bitn == 5'(FBITS - 1)) begin
              cs_n <= 1'b1;
              mosi <= 1'b1;
              st <= S_GAP;
            end else begin
              bitn <= bitn + 1'b1;
              sh <= {sh[22:0], 1'b0};
              sclk <= 1'b0;
              mosi <= sh[22];
              st <= S_LOW;
            end
          end
          S_GAP: begin
            if (last) begin
              done <= 1'b1;
              busy <= 1'b0;
              if (op_q != 2'b00) rdata <= rx[15:0];
              st <= S_IDLE;
            end else begin
              last <= 1'b1;
              cs_n <= 1'b0;
              bitn <= '0;
              sh <= (op_q == 2'b01) ? frame(2'b11, 16'h0000) : frame(2'b10, wd_q);
              st <= S_SETUP;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2
  clk_low_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !cs_n);

  // R7
  mosi_hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk) && !cs_n && $past(!cs_n)) |-> $stable(mosi));

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R1
  idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (cs_n && sclk && mosi));

  // R10
  rdata_moves_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);
endmodule

// File: tb/sim_panel_reg_spi.sv
`timescale 1ns/1ps
module sim_panel_reg_spi;
  localparam int HALF = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [7:0] req_reg = 8'h00;
  logic [15:0] req_wdata = 16'h0000;
  logic busy, done, cs_n, sclk, mosi, miso;
  logic [15:0] rdata;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  panel_reg_spi #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  // panel model
  logic [23:0] resp [0:7];
  logic [23:0] cap [0:7];
  int nbits [0:7];
  int fidx = 0, sbit = 0;
  logic [23:0] sin = '0;

  always @(negedge cs_n) begin sbit = 0; sin = '0; end
  always @(posedge sclk) if (!cs_n) begin sin = {sin[22:0], mosi}; sbit++; end
  always @(posedge cs_n) if (rst_n && fidx < 8) begin cap[fidx] = sin; nbits[fidx] = sbit; fidx++; end
  assign miso = (cs_n || sbit > 23 || fidx > 7) ? 1'b1 : resp[fidx][23 - sbit];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  int bc, ch;

  // run one access; noise injects requests mid-access (R9)
  task automatic run(input logic [1:0] op, input logic [7:0] rg, input logic [15:0] wd,
                     input logic [23:0] r1, input bit noise);
    logic [15:0] prev;
    int nf;
    prev = rdata;
    resp[0] = op[1] ? r1 : 24'hA5A5A5;
    resp[1] = r1;
    fidx = 0; bc = 0; ch = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (busy) bc++;
      if (busy && cs_n) ch++;
      if (done) break;
      if (noise && bc == 20) begin req_valid = 1'b1; req_op = 2'b10; req_reg = 8'hEE; end
      if (noise && bc == 60) req_valid = 1'b0;
      @(negedge clk);
    end
    nf = op[1] ? 1 : 2;
    chk("R9 done with busy low", {busy, done}, 2'b01);
    chk("R8 busy length", bc, 50 * HALF * nf);
    chk("R8 cs_n high gap", ch, HALF * nf);
    chk("R9 frame count", fidx, nf);
    chk("R2 frame 0 bits", nbits[0], 24);
    if (op[1]) begin
      chk("R6 status frame", cap[0], 24'h750000);
      chk("R6 status rdata", rdata, r1[15:0]);
    end else begin
      chk("R3 R4 index frame", cap[0], {16'h7400, rg});
      chk("R2 frame 1 bits", nbits[1], 24);
      if (op == 2'b00) begin
        chk("R4 data-write frame", cap[1], {8'h76, wd});
        chk("R10 rdata kept", rdata, prev);
      end else begin
        chk("R5 data-read frame", cap[1], 24'h770000);
        chk("R5 read rdata", rdata, r1[15:0]);
      end
    end
    repeat (8) @(negedge clk);
    chk("R9 idle after done", {busy, cs_n, sclk, mosi, 4'(fidx)}, {4'b0111, 4'(nf)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", {cs_n, sclk, mosi, busy, done}, 5'b11100);
    chk("R1 reset rdata", rdata, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      run(2'b00, 8'(i * 37 + 1), 16'(i * 16'h2469 + 16'h8001), 24'h0, 1'b0);
      run(2'b01, 8'(i * 29 + 3), 16'h0, 24'(i * 24'h13579B + 24'h00F00F), 1'b0);
      run(2'b10, 8'h00, 16'h0, 24'(24'hFFFFFF - i * 24'h111111), 1'b0);
    end
    run(2'b11, 8'h42, 16'h0, 24'h00C3A5, 1'b0);
    run(2'b00, 8'hFF, 16'hFFFF, 24'h0, 1'b1);
    run(2'b01, 8'h80, 16'h0, 24'h000001, 1'b1);

    // done and a held request in adjacent cycles (R9)
    resp[0] = 24'h0; resp[1] = 24'h00BEEF; fidx = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b01; req_reg = 8'h11;
    @(negedge clk);
    req_op = 2'b00; req_reg = 8'h22; req_wdata = 16'h1234;
    while (!done) @(negedge clk);
    chk("R5 read before queued write", rdata, 16'hBEEF);
    fidx = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 accept right after done", {busy, cs_n}, 2'b10);
    while (!done) @(negedge clk);
    chk("R4 queued index frame", cap[0], 24'h740022);
    chk("R4 queued data frame", cap[1], 24'h761234);
    chk("R10 rdata after queued write", rdata, 16'hBEEF);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule